// File: doc/BRIEF.md
# GPIO Port Controller Register Bank with Change Interrupt

This block is the register side of an eight-pin general purpose I/O port. A host reaches it through a plain register interface with an address, write data, a write strobe, a read strobe and registered read data. Each pin can be an input or an output on its own. Output pins are driven from a stored output value. Input pins are passed through a two-flop synchronizer and read back through a per-bit polarity inverter.

An active-low interrupt request goes low when an unmasked input pin differs from the snapshot taken at the last read of the input register. It is released by reading the input register, or when those pins return to their snapshot levels. Pin keeper selection (bus-hold, pull-up or pull-down) is exported as per-pin control bits for the pad ring.

Top module: `gpio_expander_regs`

Register map (4-bit address):

| Addr | Name | Access | Reset | Meaning |
|------|------|--------|-------|---------|
| 0h | input | RO | pins | synchronized pins XOR polarity |
| 1h | polarity | RW | 00h | 1 inverts the read of that input bit |
| 2h | keeper | RW | FFh | 1 selects bus-hold on that pin |
| 3h | pull direction | RW | FFh | 1 selects pull-up, 0 selects pull-down |
| 4h | direction | RW | 00h | 0 is input, 1 is output |
| 5h | output | RW | 00h | output flip-flops |
| 6h | irq mask | RW | FFh | 0 enables the interrupt, 1 blocks it |

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 00h) and `pin_out` = 00h. `int_n` is high and `hold_en` = FFh. Reads return 00h for polarity, direction and output, and FFh for the mask.
- R2: A write to address 1h, 2h, 3h, 4h, 5h or 6h stores `wr_data`. A read of that address with `rd_en` returns the stored value on `rd_data` at the first clock edge after the strobe.
- R3: `pin_oe` equals the direction register. A `pin_out` bit follows the output register only where the direction bit is 1, and is 0 where the direction bit is 0.
- R4: A read of address 5h returns the output flip-flops whatever the levels on `pin_in`.
- R5: A read of address 0h returns the synchronized `pin_in` XOR the polarity register. A pin change is visible to a read strobe issued two clock edges after the change.
- R6: When an input-configured pin whose mask bit is 0 changes from its snapshot, `int_n` goes low at the third clock edge after the change. Changes on pins whose mask bit is 1, or whose direction bit is 1, leave `int_n` high.
- R7: A read of address 0h loads the snapshot from the synchronized pins and drives `int_n` high at that clock edge.
- R8: When every unmasked input pin returns to its snapshot level, `int_n` goes high again without any read.
- R9: Reads of addresses 7h to Fh return 00h. Writes to those addresses and to address 0h change no register.
- R10: `pull_up_en` is 1 where the keeper bit is 0 and the pull direction bit is 1. `pull_dn_en` is 1 where both bits are 0. Both are 0 where the keeper bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously |
| addr | input | 4 | register address |
| wr_en | input | 1 | write strobe |
| wr_data | input | 8 | write data |
| rd_en | input | 1 | read strobe |
| rd_data | output | 8 | read data, registered |
| pin_in | input | 8 | pin levels from the pads |
| pin_oe | output | 8 | per-pin output enable |
| pin_out | output | 8 | per-pin output value |
| hold_en | output | 8 | per-pin bus-hold enable |
| pull_up_en | output | 8 | per-pin pull-up enable |
| pull_dn_en | output | 8 | per-pin pull-down enable |
| int_n | output | 1 | active-low interrupt request |

## Verification
The hardest case is the release of the interrupt with no read: the pending condition must first be raised against a known snapshot, and then the pin must return to exactly that snapshot. The stimulus first reads the input register so that the snapshot is known. It then toggles one unmasked pin and waits out the synchronizer, then toggles it back, and samples `int_n` on the exact edges where the change appears and clears. A pin that is set as an output and toggled under an enabled mask bit shows that the direction gate on change detection works.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_INPUT = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_POL   = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_KEEP  = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_PULL  = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_DIR   = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_OUT   = 4'h5;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 4'h6;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [WIDTH-1:0]  pins_sync,
  output logic [WIDTH-1:0]  rd_data,
  output logic              in_read,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  mask_q,
  output logic [WIDTH-1:0]  keep_q,
  output logic [WIDTH-1:0]  pull_q
);
  logic [WIDTH-1:0] pol_q, pol_d, dir_d, out_d, mask_d, keep_d, pull_d;
  logic [WIDTH-1:0] rd_q, rd_d, rd_mux;
  logic we_pol, we_dir, we_out, we_mask, we_keep, we_pull;

  assign we_pol  = wr_en && (addr == ADR_POL);
  assign we_keep = wr_en && (addr == ADR_KEEP);
  assign we_pull = wr_en && (addr == ADR_PULL);
  assign we_dir  = wr_en && (addr == ADR_DIR);
  assign we_out  = wr_en && (addr == ADR_OUT);
  assign we_mask = wr_en && (addr == ADR_MASK);
  assign in_read = rd_en && (addr == ADR_INPUT);

  always_comb begin
    pol_d  = we_pol  ? wr_data : pol_q;
    keep_d = we_keep ? wr_data : keep_q;
    pull_d = we_pull ? wr_data : pull_q;
    dir_d  = we_dir  ? wr_data : dir_q;
    out_d  = we_out  ? wr_data : out_q;
    mask_d = we_mask ? wr_data : mask_q;
  end

  always_comb begin
    case (addr)
      ADR_INPUT: rd_mux = pins_sync ^ pol_q;
      ADR_POL:   rd_mux = pol_q;
      ADR_KEEP:  rd_mux = keep_q;
      ADR_PULL:  rd_mux = pull_q;
      ADR_DIR:   rd_mux = dir_q;
      ADR_OUT:   rd_mux = out_q;
      ADR_MASK:  rd_mux = mask_q;
      default:   rd_mux = '0;
    endcase
    rd_d = rd_en ? rd_mux : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      keep_q <= '1;
      pull_q <= '1;
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '1;
      rd_q   <= '0;
    end else begin
      pol_q  <= pol_d;
      keep_q <= keep_d;
      pull_q <= pull_d;
      dir_q  <= dir_d;
      out_q  <= out_d;
      mask_q <= mask_d;
      rd_q   <= rd_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_sync,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] mask_q,
  input  logic             snap_ld,
  output logic             irq_q
);
  logic [WIDTH-1:0] snap_q, snap_d, diff;
  logic             irq_d;

  assign diff = (pins_sync ^ snap_q) & ~mask_q & ~dir_q;

  always_comb begin
    snap_d = snap_ld ? pins_sync : snap_q;
    irq_d  = snap_ld ? 1'b0 : (|diff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      snap_q <= snap_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/gpio_expander_regs.sv
module gpio_expander_regs
  import gpx_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  hold_en,
  output logic [WIDTH-1:0]  pull_up_en,
  output logic [WIDTH-1:0]  pull_dn_en,
  output logic              int_n
);
  logic [WIDTH-1:0] pins_sync, dir_q, out_q, mask_q, keep_q, pull_q;
  logic             in_read, irq_q;

  gpx_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
  );

  gpx_regfile #(.WIDTH(WIDTH)) u_rf (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .pins_sync(pins_sync),
    .rd_data(rd_data), .in_read(in_read), .dir_q(dir_q), .out_q(out_q),
    .mask_q(mask_q), .keep_q(keep_q), .pull_q(pull_q)
  );

  gpx_irq #(.WIDTH(WIDTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync), .dir_q(dir_q),
    .mask_q(mask_q), .snap_ld(in_read), .irq_q(irq_q)
  );

  assign pin_oe     = dir_q;
  assign pin_out    = out_q & dir_q;
  assign hold_en    = keep_q;
  assign pull_up_en = pull_q & ~keep_q;
  assign pull_dn_en = ~pull_q & ~keep_q;
  assign int_n      = ~irq_q;
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
  import gpx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [WIDTH-1:0]  wr_data,
  input logic              rd_en,
  input logic [WIDTH-1:0]  rd_data,
  input logic [WIDTH-1:0]  pin_oe,
  input logic [WIDTH-1:0]  out_q,
  input logic [WIDTH-1:0]  mask_q,
  input logic              int_n
);
  AST_OUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_OUT) |=> (out_q == $past(wr_data))); // R2
  AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_DIR) |=> (pin_oe == $past(wr_data))); // R3
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(&mask_q) |-> int_n); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADR_INPUT) |=> int_n); // R7
  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > ADR_MASK) |=> (rd_data == '0)); // R9
endmodule

bind gpio_expander_regs gpx_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .pin_oe(pin_oe), .out_q(out_q),
  .mask_q(mask_q), .int_n(int_n)
);

// File: tb/test_gpio_expander_regs.sv
`timescale 1ns/1ps
module test_gpio_expander_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wr_data, rd_data, pin_in;
  logic [7:0] pin_oe, pin_out, hold_en, pull_up_en, pull_dn_en;
  logic       int_n;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  gpio_expander_regs i_gpio_expander_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .hold_en(hold_en), .pull_up_en(pull_up_en),
    .pull_dn_en(pull_dn_en), .int_n(int_n)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 int_n", {7'd0, int_n}, 8'h01);
    chk("R1 hold_en", hold_en, 8'hFF);
    rd(4'h1, v); chk("R1 polarity", v, 8'h00);
    rd(4'h4, v); chk("R1 direction", v, 8'h00);
    rd(4'h5, v); chk("R1 output", v, 8'h00);
    rd(4'h6, v); chk("R1 mask", v, 8'hFF);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    for (int a = 1; a <= 6; a++) begin
      wr(4'(a), 8'(8'h30 + a * 17));
      rd(4'(a), v);
      chk("R2 readback", v, 8'(8'h30 + a * 17));
    end
    wr(4'h1, 8'h00); wr(4'h2, 8'hFF); wr(4'h3, 8'hFF);
    wr(4'h4, 8'h00); wr(4'h5, 8'h00); wr(4'h6, 8'hFF);
  endtask

  task automatic t_outputs();
    logic [7:0] v;
    pin_in = 8'h00;
    wr(4'h4, 8'h0F);
    wr(4'h5, 8'hA5);
    chk("R3 pin_oe", pin_oe, 8'h0F);
    chk("R3 pin_out gated", pin_out, 8'h05);
    rd(4'h5, v); chk("R4 output flops", v, 8'hA5);
    wr(4'h4, 8'hFF);
    chk("R3 pin_out all out", pin_out, 8'hA5);
    wr(4'h4, 8'h00);
    chk("R3 pin_out all in", pin_out, 8'h00);
  endtask

  task automatic t_input();
    logic [7:0] v;
    @(negedge clk); pin_in = 8'h3C;
    @(negedge clk);
    rd(4'h0, v); chk("R5 input plain", v, 8'h3C);
    wr(4'h1, 8'hFF);
    rd(4'h0, v); chk("R5 input inverted", v, 8'hC3);
    wr(4'h1, 8'h0F);
    rd(4'h0, v); chk("R5 input half inverted", v, 8'h33);
    wr(4'h1, 8'h00);
  endtask

  task automatic t_pull();
    wr(4'h2, 8'hF0);
    wr(4'h3, 8'hAA);
    chk("R10 hold", hold_en, 8'hF0);
    chk("R10 pull up", pull_up_en, 8'h0A);
    chk("R10 pull down", pull_dn_en, 8'h05);
    wr(4'h2, 8'hFF);
    chk("R10 all hold up", pull_up_en, 8'h00);
    chk("R10 all hold dn", pull_dn_en, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(4'h4, 8'h00);
    wr(4'h6, 8'hFF);
    @(negedge clk); pin_in = 8'h00;
    repeat (3) @(negedge clk);
    rd(4'h0, v);
    @(negedge clk); pin_in = 8'h01;
    repeat (4) @(negedge clk);
    chk("R6 masked quiet", {7'd0, int_n}, 8'h01);
    rd(4'h0, v);
    wr(4'h6, 8'hFE);
    @(negedge clk); pin_in = 8'h00;
    repeat (2) @(negedge clk);
    chk("R6 not yet", {7'd0, int_n}, 8'h01);
    @(negedge clk);
    chk("R6 asserted third edge", {7'd0, int_n}, 8'h00);
    rd(4'h0, v);
    chk("R7 read clears", {7'd0, int_n}, 8'h01);
    chk("R7 read value", v, 8'h00);
    @(negedge clk);
    chk("R7 stays clear", {7'd0, int_n}, 8'h01);
    @(negedge clk); pin_in = 8'h01;
    repeat (3) @(negedge clk);
    chk("R8 raised", {7'd0, int_n}, 8'h00);
    @(negedge clk); pin_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 back to snapshot", {7'd0, int_n}, 8'h01);
    wr(4'h4, 8'h01);
    @(negedge clk); pin_in = 8'h01;
    repeat (4) @(negedge clk);
    chk("R6 output pin ignored", {7'd0, int_n}, 8'h01);
    wr(4'h4, 8'h00);
    @(negedge clk);
    chk("R6 input again fires", {7'd0, int_n}, 8'h00);
    rd(4'h0, v);
    wr(4'h6, 8'hFF);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    wr(4'h1, 8'h00); wr(4'h4, 8'h00); wr(4'h5, 8'h00); wr(4'h6, 8'h00);
    wr(4'h7, 8'h55);
    wr(4'hF, 8'hAA);
    wr(4'h0, 8'hFF);
    rd(4'h7, v); chk("R9 read 7h", v, 8'h00);
    rd(4'hA, v); chk("R9 read Ah", v, 8'h00);
    rd(4'h1, v); chk("R9 polarity untouched", v, 8'h00);
    rd(4'h4, v); chk("R9 direction untouched", v, 8'h00);
    rd(4'h5, v); chk("R9 output untouched", v, 8'h00);
    rd(4'h6, v); chk("R9 mask untouched", v, 8'h00);
    rd(4'h0, v); chk("R9 input untouched", v, pin_in);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0;
    wr_data = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_outputs();
    t_input();
    t_pull();
    t_irq();
    t_unimpl();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule